// File: doc/BRIEF.md
# Snoop-Checked Speculative Load Queue

This block is the load-ordering tracker of an out-of-order core that keeps sequential consistency without stalling loads. Each load gets a slot in a circular queue when it is dispatched, in program order. When the load later executes speculatively, its cache-line address is written into that slot. From then until the load commits, the slot watches the remote coherence traffic. If any remote write or upgrade snoop names the same cache line, the slot is marked, because the value the load returned may now be stale.

Commit is strictly in order. The oldest slot is offered for retirement once its load has executed. An unmarked head retires and frees its slot. A marked head produces a flush request one cycle after the handshake. The request names that load's slot, and the queue drops that load and every younger one, so the refetched stream reallocates from the same slot. A load that sits behind a memory barrier stays tracked until its own commit, like any other load, so a barrier never opens a window in which a snoop goes unseen.

Two interfaces use valid/ready. On allocation, the core may hold `alloc_valid` as long as it likes, and a load is taken only in a cycle where `alloc_ready` is also high. `alloc_ready` is low when the queue is full and when the head is a marked, executed load waiting to flush. On retirement, the queue presents the head while it is executed, and the core may hold `retire_ready` low for any number of cycles. During that time the head, its index and its mark are kept, and new snoops can still mark it. Execute and snoop inputs are plain single-cycle strobes.

Top module: `ldq_snoop_guard`

## Requirements
- R1: After reset, `alloc_ready` is 1, `alloc_idx` is 0, `retire_valid` is 0 and `flush_req` is 0.
- R2: Each accepted allocation returns the current `alloc_idx`, and the next allocation gets the following slot, wrapping from DEPTH-1 to 0. `alloc_ready` is 0 while DEPTH loads are held, and also while the head is executed and marked.
- R3: `retire_valid` is 1 exactly when the oldest held load has executed. `retire_idx` names that slot, and each normal retirement moves it to the next slot with the same wrap.
- R4: A snoop marks an executed, held load when the two addresses agree in every bit above the low LINE_OFS_W offset bits. The offset bits are ignored, and a snoop to any other line leaves the load unmarked. `retire_replay` shows the head's mark.
- R5: A snoop that arrives before its load has executed never marks that load, even if the load later executes to the snooped line.
- R6: A snoop and an execute that hit the same slot and line in the same cycle leave that load marked.
- R7: Retiring an unmarked head gives `retire_replay` = 0, raises no flush, and frees the slot.
- R8: Retiring a marked head raises `flush_req` for exactly one cycle, in the cycle after the handshake, with `flush_idx` naming that slot. In that cycle the queue is empty and `alloc_idx` equals `flush_idx`.
- R9: While `retire_valid` is 1 and `retire_ready` is 0, the head index is unchanged, the head stays offered, and a mark once set is kept.
- R10: A snoop in the same cycle as the head's normal retirement does not cause a flush for that load.
- R11: An execute strobe aimed at a slot that holds no load has no effect. A load allocated there later still waits for its own execute before it is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Core offers a load for allocation |
| alloc_ready | output | 1 | Queue accepts a load this cycle |
| alloc_idx | output | IDX_W | Slot given to the load taken this cycle |
| exec_valid | input | 1 | A held load has executed |
| exec_idx | input | IDX_W | Slot of the executed load |
| exec_addr | input | ADDR_W | Byte address of the executed load |
| snoop_valid | input | 1 | Remote write or upgrade observed |
| snoop_addr | input | ADDR_W | Byte address of the snoop |
| retire_valid | output | 1 | Head load is executed and can commit |
| retire_ready | input | 1 | Core commits the head this cycle |
| retire_replay | output | 1 | Head load is marked for replay |
| retire_idx | output | IDX_W | Slot index of the head load |
| flush_req | output | 1 | One-cycle flush request for a marked load |
| flush_idx | output | IDX_W | Slot from which the flush starts |

## Verification
The bench targets several timing corners:
- A snoop that reaches a slot before its execute. A design that records the address on allocation, or that compares unexecuted slots, would mark the load wrongly.
- An execute and a snoop to the same line in one cycle. A design that compares only stored addresses would miss this and commit a stale load.
- A snoop in the cycle the head retires, which must not flush.
- A marked head held under back-pressure, where dropping the mark or moving the head would lose the replay.

The bench also fills the queue, flushes across the wrap point and sends snoops that differ only in offset bits. These cases expose an off-by-one in the full count, a tail not returned to the head, or a compare that includes offset bits.

// File: rtl/ldq_pkg.sv
package ldq_pkg;

  // Per-slot status carried from each slot to the head multiplexer.
  typedef struct packed {
    logic vld;   // slot holds a load
    logic done;  // load has executed, line address is valid
    logic mark;  // a remote write hit the line since execution
  } slot_flags_t;

endpackage

// File: rtl/ldq_slot.sv
module ldq_slot
  import ldq_pkg::*;
#(
  parameter int LINE_W = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              alloc_hit,
  input  logic              retire_hit,
  input  logic              exec_sel,
  input  logic [LINE_W-1:0] exec_line,
  input  logic              snoop_valid,
  input  logic [LINE_W-1:0] snoop_line,
  output slot_flags_t       flags
);

  logic [LINE_W-1:0] line_q;
  logic              exec_hit;
  logic              snoop_hit;

  // An execute only lands on a slot that holds a load.
  assign exec_hit = exec_sel && flags.vld;

  // The stored line is compared once executed; a same-cycle execute is
  // compared on its incoming line so the race is not lost.
  assign snoop_hit = snoop_valid && flags.vld &&
                     ((flags.done && (line_q == snoop_line)) ||
                      (exec_hit && (exec_line == snoop_line)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags  <= '0;
      line_q <= '0;
    end else if (flush || retire_hit) begin
      flags  <= '0;
    end else if (alloc_hit) begin
      flags.vld  <= 1'b1;
      flags.done <= 1'b0;
      flags.mark <= 1'b0;
    end else begin
      if (exec_hit) begin
        flags.done <= 1'b1;
        line_q     <= exec_line;
      end
      if (snoop_hit) begin
        flags.mark <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/ldq_ptrs.sv
module ldq_ptrs #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_fire,
  input  logic             retire_fire,
  input  logic             flush_now,
  output logic [IDX_W-1:0] head,
  output logic [IDX_W-1:0] tail,
  output logic             full
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] count;

  function automatic logic [IDX_W-1:0] step_idx(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full = (count == CNT_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else if (flush_now) begin
      // Flushing load and everything younger are gone; refetch reuses head.
      tail  <= head;
      count <= '0;
    end else begin
      if (alloc_fire)  tail <= step_idx(tail);
      if (retire_fire) head <= step_idx(head);
      count <= count + CNT_W'(alloc_fire) - CNT_W'(retire_fire);
    end
  end

endmodule

// File: rtl/ldq_snoop_guard.sv
module ldq_snoop_guard
  import ldq_pkg::*;
#(
  parameter int DEPTH      = 8,
  parameter int ADDR_W     = 32,
  parameter int LINE_OFS_W = 6,
  localparam int IDX_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LINE_W    = ADDR_W - LINE_OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  output logic              alloc_ready,
  output logic [IDX_W-1:0]  alloc_idx,
  input  logic              exec_valid,
  input  logic [IDX_W-1:0]  exec_idx,
  input  logic [ADDR_W-1:0] exec_addr,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              retire_valid,
  input  logic              retire_ready,
  output logic              retire_replay,
  output logic [IDX_W-1:0]  retire_idx,
  output logic              flush_req,
  output logic [IDX_W-1:0]  flush_idx
);

  logic [IDX_W-1:0]  head;
  logic [IDX_W-1:0]  tail;
  logic              full;
  logic              alloc_fire;
  logic              retire_fire;
  logic              flush_now;
  logic              head_blocked;
  logic [LINE_W-1:0] exec_line;
  logic [LINE_W-1:0] snoop_line;
  slot_flags_t       slot_flags [DEPTH];
  slot_flags_t       head_flags;
  logic              unused_ofs;

  assign exec_line  = exec_addr[ADDR_W-1:LINE_OFS_W];
  assign snoop_line = snoop_addr[ADDR_W-1:LINE_OFS_W];
  assign unused_ofs = ^{exec_addr[LINE_OFS_W-1:0], snoop_addr[LINE_OFS_W-1:0]};

  assign head_flags    = slot_flags[head];
  assign retire_valid  = head_flags.vld && head_flags.done;
  assign retire_replay = head_flags.mark;
  assign retire_idx    = head;
  assign head_blocked  = retire_valid && head_flags.mark;

  assign alloc_ready = !full && !head_blocked;
  assign alloc_idx   = tail;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign retire_fire = retire_valid && retire_ready;
  assign flush_now   = retire_fire && retire_replay;

  ldq_ptrs #(
    .DEPTH (DEPTH),
    .IDX_W (IDX_W)
  ) u_ptrs (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_fire  (alloc_fire),
    .retire_fire (retire_fire && !retire_replay),
    .flush_now   (flush_now),
    .head        (head),
    .tail        (tail),
    .full        (full)
  );

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    ldq_slot #(
      .LINE_W (LINE_W)
    ) u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .flush       (flush_now),
      .alloc_hit   (alloc_fire && (tail == IDX_W'(g))),
      .retire_hit  (retire_fire && (head == IDX_W'(g))),
      .exec_sel    (exec_valid && (exec_idx == IDX_W'(g))),
      .exec_line   (exec_line),
      .snoop_valid (snoop_valid),
      .snoop_line  (snoop_line),
      .flags       (slot_flags[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flush_req <= 1'b0;
      flush_idx <= '0;
    end else begin
      flush_req <= flush_now;
      if (flush_now) flush_idx <= head;
    end
  end

endmodule

// File: rtl/ldq_snoop_guard_sva.sv
module ldq_snoop_guard_sva #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_valid,
  input logic             alloc_ready,
  input logic [IDX_W-1:0] alloc_idx,
  input logic             retire_valid,
  input logic             retire_ready,
  input logic             retire_replay,
  input logic [IDX_W-1:0] retire_idx,
  input logic             flush_req,
  input logic [IDX_W-1:0] flush_idx
);

  function automatic logic [IDX_W-1:0] nxt(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  AST_ALLOC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid && alloc_ready |=> alloc_idx == nxt($past(alloc_idx))); // R2

  AST_RETIRE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    retire_valid && retire_ready && !retire_replay |=> retire_idx == nxt($past(retire_idx))); // R3

  AST_CLEAN_NO_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    retire_valid && retire_ready && !retire_replay |=> !flush_req); // R7

  AST_REPLAY_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    retire_valid && retire_ready && retire_replay |=> flush_req && flush_idx == $past(retire_idx)); // R8

  AST_FLUSH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> !flush_req); // R8

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> !retire_valid && alloc_idx == flush_idx); // R8

  AST_HOLD_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    retire_valid && !retire_ready |=> retire_valid && $stable(retire_idx) && (retire_replay || !$past(retire_replay))); // R9

  AST_MARK_BLOCKS_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    retire_valid && retire_replay |-> !alloc_ready); // R2

endmodule

bind ldq_snoop_guard ldq_snoop_guard_sva #(
  .DEPTH (DEPTH),
  .IDX_W (IDX_W)
) u_sva (
  .clk           (clk),
  .rst_n         (rst_n),
  .alloc_valid   (alloc_valid),
  .alloc_ready   (alloc_ready),
  .alloc_idx     (alloc_idx),
  .retire_valid  (retire_valid),
  .retire_ready  (retire_ready),
  .retire_replay (retire_replay),
  .retire_idx    (retire_idx),
  .flush_req     (flush_req),
  .flush_idx     (flush_idx)
);

// File: tb/ldq_snoop_guard_tb.sv
`timescale 1ns/1ps
module ldq_snoop_guard_tb;

  localparam int DEPTH  = 8;
  localparam int ADDR_W = 32;
  localparam int OFS_W  = 6;
  localparam int IDX_W  = 3;
  localparam int LINE_W = ADDR_W - OFS_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              alloc_valid = 1'b0;
  logic              alloc_ready;
  logic [IDX_W-1:0]  alloc_idx;
  logic              exec_valid = 1'b0;
  logic [IDX_W-1:0]  exec_idx = '0;
  logic [ADDR_W-1:0] exec_addr = '0;
  logic              snoop_valid = 1'b0;
  logic [ADDR_W-1:0] snoop_addr = '0;
  logic              retire_valid;
  logic              retire_ready = 1'b0;
  logic              retire_replay;
  logic [IDX_W-1:0]  retire_idx;
  logic              flush_req;
  logic [IDX_W-1:0]  flush_idx;

  int n_chk = 0;
  int n_err = 0;

  // Reference state, built from the requirements.
  bit              m_vld  [DEPTH];
  bit              m_done [DEPTH];
  bit              m_mark [DEPTH];
  bit [LINE_W-1:0] m_line [DEPTH];
  int              m_head = 0, m_tail = 0, m_cnt = 0, m_fidx = 0;
  bit              m_fq = 0;

  always #2.5 clk = ~clk;

  ldq_snoop_guard #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .LINE_OFS_W(OFS_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
    .exec_valid(exec_valid), .exec_idx(exec_idx), .exec_addr(exec_addr),
    .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
    .retire_valid(retire_valid), .retire_ready(retire_ready),
    .retire_replay(retire_replay), .retire_idx(retire_idx),
    .flush_req(flush_req), .flush_idx(flush_idx)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  function automatic int wrap1(input int p);
    return (p == DEPTH - 1) ? 0 : p + 1;
  endfunction

  function automatic bit exp_ready();
    return (m_cnt < DEPTH) && !(m_vld[m_head] && m_done[m_head] && m_mark[m_head]);
  endfunction

  function automatic bit exp_rvalid();
    return m_vld[m_head] && m_done[m_head];
  endfunction

  task automatic compare_all();
    chk("R2 alloc_ready", int'(alloc_ready), int'(exp_ready()));
    chk("R2 alloc_idx", int'(alloc_idx), m_tail);
    chk("R3 retire_valid", int'(retire_valid), int'(exp_rvalid()));
    chk("R3 retire_idx", int'(retire_idx), m_head);
    if (exp_rvalid()) chk("R4 retire_replay", int'(retire_replay), int'(m_mark[m_head]));
    chk("R8 flush_req", int'(flush_req), int'(m_fq));
    if (m_fq) chk("R8 flush_idx", int'(flush_idx), m_fidx);
  endtask

  task automatic idle();
    alloc_valid = 0; exec_valid = 0; snoop_valid = 0; retire_ready = 0;
  endtask

  // One clock: predict, let the edge pass, adopt the prediction, compare.
  task automatic tick();
    bit              nv [DEPTH];
    bit              nd [DEPTH];
    bit              nm [DEPTH];
    bit [LINE_W-1:0] nl [DEPTH];
    bit afire, rfire, fl, eh;
    bit [LINE_W-1:0] el, sl;
    int nh, nt, nc;
    afire = alloc_valid && exp_ready();
    rfire = retire_ready && exp_rvalid();
    fl    = rfire && m_mark[m_head];
    el = exec_addr[ADDR_W-1:OFS_W];
    sl = snoop_addr[ADDR_W-1:OFS_W];
    nh = m_head; nt = m_tail; nc = m_cnt;
    for (int i = 0; i < DEPTH; i++) begin
      nv[i] = m_vld[i]; nd[i] = m_done[i]; nm[i] = m_mark[i]; nl[i] = m_line[i];
      if (fl || (rfire && i == m_head)) begin
        nv[i] = 0; nd[i] = 0; nm[i] = 0;
      end else if (afire && i == m_tail) begin
        nv[i] = 1; nd[i] = 0; nm[i] = 0;
      end else if (m_vld[i]) begin
        eh = exec_valid && (int'(exec_idx) == i);
        if (snoop_valid && ((m_done[i] && m_line[i] == sl) || (eh && el == sl))) nm[i] = 1;
        if (eh) begin nd[i] = 1; nl[i] = el; end
      end
    end
    if (fl) begin
      nt = m_head; nc = 0;
    end else begin
      if (afire) nt = wrap1(m_tail);
      if (rfire) nh = wrap1(m_head);
      nc = m_cnt + int'(afire) - int'(rfire);
    end
    @(posedge clk);
    if (fl) m_fidx = m_head;
    m_fq = fl;
    for (int i = 0; i < DEPTH; i++) begin
      m_vld[i] = nv[i]; m_done[i] = nd[i]; m_mark[i] = nm[i]; m_line[i] = nl[i];
    end
    m_head = nh; m_tail = nt; m_cnt = nc;
    @(negedge clk);
    compare_all();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    #(5.0 * 200000);
    n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int st;
    void'($urandom(32'd2024));
    for (int i = 0; i < DEPTH; i++) begin
      m_vld[i] = 0; m_done[i] = 0; m_mark[i] = 0; m_line[i] = '0;
    end
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1 alloc_ready", int'(alloc_ready), 1);
    chk("R1 alloc_idx", int'(alloc_idx), 0);
    chk("R1 retire_valid", int'(retire_valid), 0);
    chk("R1 flush_req", int'(flush_req), 0);

    // R5 and R7: snoop before execute, then clean retirement
    idle(); alloc_valid = 1; tick();
    idle(); snoop_valid = 1; snoop_addr = 32'h0000_0400; tick();
    idle(); exec_valid = 1; exec_idx = 0; exec_addr = 32'h0000_0408; tick();
    idle();
    chk("R5 early snoop no mark", int'(retire_replay), 0);
    retire_ready = 1; tick(); idle();
    chk("R7 no flush on clean retire", int'(flush_req), 0);
    chk("R7 slot freed", int'(retire_valid), 0);

    // R6, R9, R8: same-cycle execute and snoop, hold, then flush
    alloc_valid = 1; tick(); idle();
    exec_valid = 1; exec_idx = 1; exec_addr = 32'h0000_0800;
    snoop_valid = 1; snoop_addr = 32'h0000_083C; tick(); idle();
    chk("R6 race marks load", int'(retire_replay), 1);
    chk("R2 mark blocks alloc", int'(alloc_ready), 0);
    alloc_valid = 1;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R9 head held", int'(retire_valid), 1);
      chk("R9 mark kept", int'(retire_replay), 1);
      chk("R9 index kept", int'(retire_idx), 1);
    end
    alloc_valid = 0; retire_ready = 1; tick(); idle();
    chk("R8 flush raised", int'(flush_req), 1);
    chk("R8 flush names slot", int'(flush_idx), 1);
    chk("R8 tail back to slot", int'(alloc_idx), 1);
    tick();
    chk("R8 flush one cycle", int'(flush_req), 0);

    // R4: line granularity
    alloc_valid = 1; tick(); idle();
    exec_valid = 1; exec_idx = 1; exec_addr = 32'h0000_1000; tick(); idle();
    snoop_valid = 1; snoop_addr = 32'h0000_1040; tick(); idle();
    chk("R4 other line ignored", int'(retire_replay), 0);
    snoop_valid = 1; snoop_addr = 32'h0000_103F; tick(); idle();
    chk("R4 same line marks", int'(retire_replay), 1);
    retire_ready = 1; tick(); idle(); tick();

    // R10: snoop during clean retirement
    alloc_valid = 1; tick(); idle();
    exec_valid = 1; exec_idx = 3'(m_head); exec_addr = 32'h0000_2000; tick(); idle();
    retire_ready = 1; snoop_valid = 1; snoop_addr = 32'h0000_2004; tick(); idle();
    chk("R10 no flush", int'(flush_req), 0);
    chk("R10 retired", int'(retire_valid), 0);

    // R2: fill to DEPTH, then flush across the wrap
    st = m_tail;
    alloc_valid = 1;
    repeat (DEPTH) tick();
    chk("R2 full blocks", int'(alloc_ready), 0);
    chk("R2 tail wrapped", int'(alloc_idx), st);
    idle();
    exec_valid = 1; exec_idx = 3'(m_head); exec_addr = 32'h0000_3000;
    snoop_valid = 1; snoop_addr = 32'h0000_3000; tick(); idle();
    retire_ready = 1; tick(); idle();
    chk("R8 flush after full", int'(flush_req), 1);
    tick();

    // R11: execute to an empty slot
    exec_valid = 1; exec_idx = 3'(m_tail); exec_addr = 32'h0000_4000; tick(); idle();
    chk("R11 empty exec ignored", int'(retire_valid), 0);
    alloc_valid = 1; tick(); idle();
    chk("R11 new load unexecuted", int'(retire_valid), 0);

    // Constrained random traffic over a small line pool
    for (int c = 0; c < 4000; c++) begin
      alloc_valid  = ($urandom % 3) != 0;
      exec_valid   = ($urandom % 2) != 0;
      exec_idx     = 3'($urandom % DEPTH);
      exec_addr    = (($urandom % 6) << OFS_W) | ($urandom % 64);
      snoop_valid  = ($urandom % 5) == 0;
      snoop_addr   = (($urandom % 6) << OFS_W) | ($urandom % 64);
      retire_ready = ($urandom % 3) != 0;
      tick();
    end
    idle();
    summary();
    $finish;
  end

endmodule